// File: doc/BRIEF.md
# Repartitionable Direct-Mapped Cache Controller

This block is a direct-mapped, write-through cache placed between a processor's local request port and an external burst memory bus. A single storage array of `NUM_LINES` lines of 16 bytes (8 KB with the default of 512 lines) can be given over entirely to instruction fetches, entirely to data accesses, or divided so that one half serves instructions and the other half serves data. The organisation is chosen through a mode input. The array is cleared of all valid lines whenever the mode changes or the invalidate strobe is pulsed.

A read hit completes in the same cycle it is presented. A read miss fetches the whole line as a four-beat burst that starts with the requested word. The core is released on that first beat while the remaining beats gather in a line buffer. The line buffer is then written into the array in one step. Every write goes out on the external bus as a single-beat cycle. A write hit also updates the cached word, and a write miss allocates nothing. Requests whose type has no partition in the current mode bypass the array as single-beat external cycles.

The core holds `req_i` and its attributes until it sees `ready_o`. The external side holds `ext_req_o` and its attributes until `ext_valid_i`, which marks each read beat or the acknowledge of a write.

Top module: `split_cache`

## Requirements
- R1: `cfg_mode_i` encodes the organisation: 2'b00 instruction-only, 2'b01 data-only, 2'b10 split, 2'b11 all bypass. A request whose type (`instr_i`) has no partition is served as a single-beat external cycle (`ext_burst_o`=0) and allocates no line.
- R2: `addr_i[3:2]` selects the word in a line. Unsplit modes index lines with `addr_i[4 +: IDX_W]`. Split mode indexes with `addr_i[4 +: IDX_W-1]`, and the top index bit is 1 for data and 0 for instructions. The two sides never evict each other.
- R3: A cacheable read that hits asserts `ready_o` with the cached word in the cycle it is presented and starts no external cycle.
- R4: A cacheable read miss issues one burst (`ext_burst_o`=1, `ext_we_o`=0) at the requested word address. The four beats arrive in wrap order starting from that word, and afterwards every word of the line hits with its memory value.
- R5: On a miss, `ready_o` pulses once, together with the first beat, carrying the requested word while the burst is still in progress.
- R6: Every write, cached or not, produces one single-beat external write of the address and data, and `ready_o` is given when it is acknowledged.
- R7: A write that hits also updates the cached word, so a later read of it hits with the new data.
- R8: A write miss allocates no line, so a later read of that address misses.
- R9: A mode change or an `inval_i` pulse clears every valid bit before the next lookup is accepted.
- R10: After reset `ready_o` and `ext_req_o` are low and all lines are invalid.
- R11: While `ext_req_o` is high and not yet acknowledged, `ext_addr_o` and `ext_we_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mode_i | input | 2 | Array organisation |
| inval_i | input | 1 | Invalidate-all strobe |
| req_i | input | 1 | Core request valid |
| addr_i | input | 32 | Core byte address |
| instr_i | input | 1 | 1 = instruction fetch, 0 = data access |
| we_i | input | 1 | 1 = write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Request completes |
| ext_req_o | output | 1 | External cycle request |
| ext_we_o | output | 1 | External write |
| ext_burst_o | output | 1 | Four-beat line read |
| ext_addr_o | output | 32 | External word address (critical word for bursts) |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data beat |
| ext_valid_i | input | 1 | Read beat valid or write acknowledge |

## Verification
Reads are tried at the first, middle and last words of a line, so a wrong wrap order or a misplaced buffer slot shows up as a bad word on a later hit. Pairs of addresses that alias only in one organisation are used in each mode. This separates the unsplit index from the split one, and it shows whether instruction and data halves stay independent. Write hits, write misses and type-bypassed requests are each followed by a read of the same address. The external cycle count and burst flag of that read tell allocation, update and bypass apart. Invalidate pulses and mode switches are followed by reads of lines that hit just before.

// File: rtl/split_cache_pkg.sv
package split_cache_pkg;
  typedef enum logic [1:0] {
    MODE_INSTR = 2'b00,
    MODE_DATA  = 2'b01,
    MODE_SPLIT = 2'b10,
    MODE_OFF   = 2'b11
  } cache_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE,
    ST_SINGLE
  } ctrl_state_e;
endpackage

// File: rtl/sc_route.sv
module sc_route
  import split_cache_pkg::*;
#(
  parameter int NUM_LINES  = 512,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int OFF_W = $clog2(LINE_WORDS) + 2,
  localparam int TAG_W = 32 - OFF_W
) (
  input  cache_mode_e       mode_i,
  input  logic              instr_i,
  input  logic [31:0]       addr_i,
  output logic              cacheable_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  always_comb begin
    unique case (mode_i)
      MODE_INSTR: cacheable_o = instr_i;
      MODE_DATA:  cacheable_o = ~instr_i;
      MODE_SPLIT: cacheable_o = 1'b1;
      default:    cacheable_o = 1'b0;
    endcase
    // split: top index bit picks the half, data in the upper half
    if (mode_i == MODE_SPLIT) idx_o = {~instr_i, addr_i[OFF_W +: IDX_W-1]};
    else                      idx_o = addr_i[OFF_W +: IDX_W];
    tag_o = addr_i[31:OFF_W];
  end
endmodule

// File: rtl/sc_store.sv
module sc_store #(
  parameter int NUM_LINES  = 512,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 28,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int WW    = $clog2(LINE_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  input  logic [WW-1:0]            rd_word_i,
  input  logic [TAG_W-1:0]         rd_tag_i,
  output logic                     rd_hit_o,
  output logic [31:0]              rd_data_o,
  input  logic                     lw_en_i,
  input  logic [IDX_W-1:0]         lw_idx_i,
  input  logic [TAG_W-1:0]         lw_tag_i,
  input  logic [LINE_WORDS*32-1:0] lw_data_i,
  input  logic                     ww_en_i,
  input  logic [IDX_W-1:0]         ww_idx_i,
  input  logic [WW-1:0]            ww_word_i,
  input  logic [31:0]              ww_data_i
);
  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [31:0]          data_q [NUM_LINES*LINE_WORDS];

  assign rd_hit_o  = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_data_o = data_q[{rd_idx_i, rd_word_i}];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (lw_en_i) valid_q[lw_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (lw_en_i) begin
      tag_q[lw_idx_i] <= lw_tag_i;
      for (int w = 0; w < LINE_WORDS; w++)
        data_q[{lw_idx_i, WW'(w)}] <= lw_data_i[w*32 +: 32];
    end
    if (ww_en_i) data_q[{ww_idx_i, ww_word_i}] <= ww_data_i;
  end

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  a_r10_reset_invalid: assert property (@(posedge clk_i)
    !rst_ni |=> (valid_q == '0));
endmodule

// File: rtl/sc_linebuf.sv
module sc_linebuf #(
  parameter int LINE_WORDS = 4,
  localparam int WW = $clog2(LINE_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [WW-1:0]            crit_i,
  input  logic                     beat_i,
  input  logic [31:0]              beat_data_i,
  output logic                     first_o,
  output logic                     last_o,
  output logic [LINE_WORDS*32-1:0] line_o
);
  logic [WW-1:0] cnt_q, crit_q, pos;
  logic [31:0]   buf_q [LINE_WORDS];

  assign pos     = crit_q + cnt_q;  // wrap order from the critical word
  assign first_o = beat_i && (cnt_q == '0);
  assign last_o  = beat_i && (cnt_q == WW'(LINE_WORDS-1));

  always_comb
    for (int w = 0; w < LINE_WORDS; w++)
      line_o[w*32 +: 32] = (beat_i && pos == WW'(w)) ? beat_data_i : buf_q[w];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      crit_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      crit_q <= crit_i;
    end else if (beat_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i)
    if (beat_i) buf_q[pos] <= beat_data_i;
endmodule

// File: rtl/split_cache.sv
module split_cache
  import split_cache_pkg::*;
#(
  parameter int NUM_LINES  = 512,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int WW    = $clog2(LINE_WORDS),
  localparam int OFF_W = WW + 2,
  localparam int TAG_W = 32 - OFF_W
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  cfg_mode_i,
  input  logic        inval_i,
  input  logic        req_i,
  input  logic [31:0] addr_i,
  input  logic        instr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        ready_o,
  output logic        ext_req_o,
  output logic        ext_we_o,
  output logic        ext_burst_o,
  output logic [31:0] ext_addr_o,
  output logic [31:0] ext_wdata_o,
  input  logic [31:0] ext_rdata_i,
  input  logic        ext_valid_i
);
  ctrl_state_e state_q, state_d;
  cache_mode_e mode_q;
  logic        flush_pend_q, flush_req, flush_go, lookup;
  logic [31:2] addr_q;
  logic [31:0] wdata_q;
  logic [IDX_W-1:0] idx_q, rt_idx;
  logic [TAG_W-1:0] rt_tag;
  logic        rt_cacheable, hit;
  logic [31:0] arr_rdata;
  logic        lw_en, ww_en, fill_start, beat, fill_first, fill_last;
  logic [LINE_WORDS*32-1:0] fill_line;

  assign flush_req = inval_i || flush_pend_q || (cfg_mode_i != mode_q);
  assign flush_go  = (state_q == ST_IDLE) && flush_req;
  assign lookup    = (state_q == ST_IDLE) && !flush_req && req_i;
  assign beat      = (state_q == ST_FILL) && ext_valid_i;

  sc_route #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS)) u_route (
    .mode_i(mode_q), .instr_i(instr_i), .addr_i(addr_i),
    .cacheable_o(rt_cacheable), .idx_o(rt_idx), .tag_o(rt_tag)
  );

  sc_store #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni, .flush_i(flush_go),
    .rd_idx_i(rt_idx), .rd_word_i(addr_i[OFF_W-1:2]), .rd_tag_i(rt_tag),
    .rd_hit_o(hit), .rd_data_o(arr_rdata),
    .lw_en_i(lw_en), .lw_idx_i(idx_q), .lw_tag_i(addr_q[31:OFF_W]), .lw_data_i(fill_line),
    .ww_en_i(ww_en), .ww_idx_i(rt_idx), .ww_word_i(addr_i[OFF_W-1:2]), .ww_data_i(wdata_i)
  );

  sc_linebuf #(.LINE_WORDS(LINE_WORDS)) u_linebuf (
    .clk_i, .rst_ni, .start_i(fill_start), .crit_i(addr_i[OFF_W-1:2]),
    .beat_i(beat), .beat_data_i(ext_rdata_i),
    .first_o(fill_first), .last_o(fill_last), .line_o(fill_line)
  );

  always_comb begin
    state_d    = state_q;
    ready_o    = 1'b0;
    rdata_o    = arr_rdata;
    lw_en      = 1'b0;
    ww_en      = 1'b0;
    fill_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (lookup) begin
        if (we_i) begin
          state_d = ST_WRITE;
          ww_en   = rt_cacheable && hit;
        end else if (rt_cacheable && hit) begin
          ready_o = 1'b1;
        end else if (rt_cacheable) begin
          state_d    = ST_FILL;
          fill_start = 1'b1;
        end else begin
          state_d = ST_SINGLE;
        end
      end
      ST_FILL: if (ext_valid_i) begin
        if (fill_first) begin
          ready_o = 1'b1;
          rdata_o = ext_rdata_i;
        end
        if (fill_last) begin
          lw_en   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: if (ext_valid_i) begin
        ready_o = 1'b1;
        state_d = ST_IDLE;
      end
      default: if (ext_valid_i) begin
        ready_o = 1'b1;
        rdata_o = ext_rdata_i;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_OFF;
      flush_pend_q <= 1'b0;
      addr_q       <= '0;
      wdata_q      <= '0;
      idx_q        <= '0;
    end else begin
      state_q      <= state_d;
      flush_pend_q <= flush_req && !flush_go;
      if (flush_go) mode_q <= cache_mode_e'(cfg_mode_i);
      if (lookup) begin
        addr_q  <= addr_i[31:2];
        wdata_q <= wdata_i;
        idx_q   <= rt_idx;
      end
    end
  end

  assign ext_req_o   = (state_q != ST_IDLE);
  assign ext_we_o    = (state_q == ST_WRITE);
  assign ext_burst_o = (state_q == ST_FILL);
  assign ext_addr_o  = {addr_q, 2'b00};
  assign ext_wdata_o = wdata_q;

  // checker state: core released at most once per fill
  logic released_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 released_q <= 1'b0;
    else if (state_q != ST_FILL) released_q <= 1'b0;
    else if (ready_o)            released_q <= 1'b1;
  end

  a_r5_single_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && released_q) |-> !ready_o);
  a_r3_hit_stays_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_req_o && ready_o) |=> !ext_req_o);
  a_r6_write_single_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && ext_we_o) |-> !ext_burst_o);
  a_r11_ext_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_valid_i) |=> (ext_req_o && $stable(ext_addr_o) && $stable(ext_we_o)));
  a_r9_no_lookup_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_req_o && inval_i) |-> !ready_o);
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!ext_req_o && !ready_o));
endmodule

// File: tb/split_cache_bench.sv
module split_cache_bench;
  localparam int NUM_LINES = 512;
  localparam logic [31:0] FULL_SPAN = NUM_LINES * 16;
  localparam logic [31:0] HALF_SPAN = NUM_LINES * 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_mode_i = 2'b11;
  logic        inval_i = 1'b0, req_i = 1'b0, instr_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] rdata_o, ext_addr_o, ext_wdata_o;
  logic        ready_o, ext_req_o, ext_we_o, ext_burst_o;
  logic [31:0] ext_rdata_i = '0;
  logic        ext_valid_i = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  split_cache #(.NUM_LINES(NUM_LINES)) u_split_cache (
    .clk_i(clk), .rst_ni, .cfg_mode_i, .inval_i, .req_i, .addr_i, .instr_i,
    .we_i, .wdata_i, .rdata_o, .ready_o, .ext_req_o, .ext_we_o, .ext_burst_o,
    .ext_addr_o, .ext_wdata_o, .ext_rdata_i, .ext_valid_i
  );

  // external memory model
  logic [31:0] wmem [logic [31:0]];
  function automatic logic [31:0] mread(logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  int txn_cnt = 0;
  bit s_busy = 0, s_burst = 0, s_we = 0;
  int s_dly = 0, s_beat = 0;
  logic [31:0] s_addr = '0, s_wdata = '0;

  always @(negedge clk) begin
    ext_valid_i = 1'b0;
    if (s_busy) begin
      if (s_dly > 0) s_dly--;
      else begin
        ext_valid_i = 1'b1;
        if (s_we) begin
          wmem[s_addr] = s_wdata;
          s_busy = 0;
        end else begin
          ext_rdata_i = mread({s_addr[31:4], 4'(s_addr[3:0] + 4'(s_beat*4))});
          s_beat++;
          if (!s_burst || s_beat == 4) s_busy = 0;
        end
      end
    end else if (ext_req_o) begin
      s_busy = 1; s_dly = 1; s_beat = 0; txn_cnt++;
      s_burst = ext_burst_o; s_we = ext_we_o; s_addr = ext_addr_o; s_wdata = ext_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic ins, input logic w, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output int txn, output bit busy_at_rel);
    int t0;
    t0 = txn_cnt;
    @(negedge clk);
    req_i = 1'b1; addr_i = a; instr_i = ins; we_i = w; wdata_i = wd;
    cyc = 0;
    #1;
    while (!ready_o) begin
      @(negedge clk); #1; cyc++;
    end
    rd = rdata_o;
    busy_at_rel = ext_req_o && !ext_valid_i ? 1'b1 : (ext_req_o && s_busy);
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
    while (ext_req_o) @(negedge clk);
    txn = txn_cnt - t0;
  endtask

  task automatic rd_expect(input logic [31:0] a, input logic ins, input int exp_txn, input string req);
    logic [31:0] rd; int cyc, txn; bit b;
    access(a, ins, 1'b0, '0, rd, cyc, txn, b);
    chk(rd == mread(a), req, rd, mread(a));
    chk(txn == exp_txn, req, txn, exp_txn);
    if (exp_txn == 0) chk(cyc == 0, req, cyc, 0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); cfg_mode_i = m;
  endtask

  task t_reset;
    #1;
    chk(ready_o == 1'b0, "R10 ready", ready_o, 0);
    chk(ext_req_o == 1'b0, "R10 ext_req", ext_req_o, 0);
  endtask

  task t_miss_fill;
    logic [31:0] rd; int cyc, txn; bit b;
    set_mode(2'b01);
    access(32'h108, 1'b0, 1'b0, '0, rd, cyc, txn, b);
    chk(rd == mread(32'h108), "R5 critical word", rd, mread(32'h108));
    chk(b == 1'b1, "R5 released mid burst", b, 1);
    chk(txn == 1, "R4 one burst", txn, 1);
    chk(s_burst == 1'b1, "R4 burst flag", s_burst, 1);
    chk(s_addr == 32'h108, "R4 critical address", s_addr, 32'h108);
    rd_expect(32'h10C, 1'b0, 0, "R4 wrap word3");
    rd_expect(32'h100, 1'b0, 0, "R4 wrap word0");
    rd_expect(32'h104, 1'b0, 0, "R3 hit word1");
    rd_expect(32'h108, 1'b0, 0, "R3 hit word2");
  endtask

  task t_write;
    logic [31:0] rd; int cyc, txn; bit b;
    access(32'h104, 1'b0, 1'b1, 32'hDEAD_BEEF, rd, cyc, txn, b);
    chk(txn == 1, "R6 write hit cycle", txn, 1);
    chk(s_we == 1'b1 && s_burst == 1'b0, "R6 single write", {s_we, s_burst}, 2'b10);
    chk(wmem[32'h104] == 32'hDEAD_BEEF, "R6 memory data", wmem[32'h104], 32'hDEAD_BEEF);
    rd_expect(32'h104, 1'b0, 0, "R7 write hit updates");
    access(32'h300, 1'b0, 1'b1, 32'h1234_5678, rd, cyc, txn, b);
    chk(txn == 1, "R6 write miss cycle", txn, 1);
    rd_expect(32'h300, 1'b0, 1, "R8 no allocate");
  endtask

  task t_conflict;
    rd_expect(32'h100 + FULL_SPAN, 1'b0, 1, "R2 alias miss");
    rd_expect(32'h100, 1'b0, 1, "R2 evicted");
  endtask

  task t_split;
    set_mode(2'b10);
    rd_expect(32'h100, 1'b0, 1, "R9 mode change flush");
    rd_expect(32'h400, 1'b1, 1, "R1 instr fill");
    rd_expect(32'h400, 1'b0, 1, "R2 data side separate");
    rd_expect(32'h400, 1'b1, 0, "R2 instr kept");
    rd_expect(32'h400, 1'b0, 0, "R2 data kept");
    rd_expect(32'h400 + HALF_SPAN, 1'b0, 1, "R2 split alias");
    rd_expect(32'h400, 1'b0, 1, "R2 split evicted");
    rd_expect(32'h400, 1'b1, 0, "R2 instr unaffected");
  endtask

  task t_bypass;
    set_mode(2'b00);
    rd_expect(32'h500, 1'b0, 1, "R1 data bypass");
    chk(s_burst == 1'b0, "R1 bypass single beat", s_burst, 0);
    rd_expect(32'h500, 1'b0, 1, "R1 bypass no allocate");
    rd_expect(32'h600, 1'b1, 1, "R1 instr cached");
    rd_expect(32'h600, 1'b1, 0, "R1 instr hit");
    set_mode(2'b11);
    rd_expect(32'h600, 1'b1, 1, "R1 off bypass");
    chk(s_burst == 1'b0, "R1 off single beat", s_burst, 0);
  endtask

  task t_inval;
    set_mode(2'b01);
    rd_expect(32'h700, 1'b0, 1, "R9 fill");
    rd_expect(32'h700, 1'b0, 0, "R9 hit");
    @(negedge clk); inval_i = 1'b1;
    @(negedge clk); inval_i = 1'b0;
    rd_expect(32'h700, 1'b0, 1, "R9 invalidated");
  endtask

  initial begin
    t_reset;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_miss_fill;
    t_write;
    t_conflict;
    t_split;
    t_bypass;
    t_inval;
    repeat (4) @(negedge clk);
    chk(u_split_cache.ext_req_o == 1'b0, "R11 bus idle", ext_req_o, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule